// File: doc/BRIEF.md
# OTP Fuse Read Sequencer

This block is a hardware controller that reads a run of consecutive 32-bit words out of a one-time-programmable fuse macro. It accepts one request at a time, made of a start byte offset and a byte length. It validates the request, then drives the macro's pins directly: it brings the macro out of deep standby, enables trim, and enables the macro. For each word it runs one timed pulse of the macro clock and samples the data-out bus. It then powers the macro down in the reverse order.

Each word is returned on a valid/ready stream. The sequencer does not start the next word until the current one has been accepted. Every request ends with a one-cycle done pulse, or with a one-cycle error pulse if the request was rejected. All delays are parameters counted in system clock cycles. The defaults give 40 µs high and 10 µs low at 50 MHz.

Top module: `otp_read_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1. `fuse_stby_no`, `fuse_trim_o`, `fuse_en_o`, `fuse_clk_o`, `word_valid_o`, `done_o` and `err_o` are all 0.
- R2: A request whose offset or length has a nonzero bit 1 or bit 0 is rejected. `err_o` pulses for exactly one cycle, in the cycle after acceptance. No macro pin changes and no word is produced.
- R3: A request whose offset or length has bit 31 set (negative as a signed value) is rejected in the same way as R2.
- R4: Let start = offset/4 and count = length/4. A request with start >= FUSE_COUNT, or with start + count > FUSE_COUNT, is rejected in the same way as R2. A request that ends exactly at FUSE_COUNT is accepted.
- R5: Power-up order is fixed. `fuse_stby_no` rises first. `fuse_trim_o` rises STEP_CYCLES cycles later. `fuse_en_o` rises STEP_CYCLES cycles after that.
- R6: Each word gets one pulse on `fuse_clk_o`, high for exactly HI_CYCLES cycles and then low for at least LO_CYCLES cycles. The clock rises one cycle after the address is presented: STEP_CYCLES+1 cycles after `fuse_en_o` rises for the first word, and one cycle after the previous word is accepted for later words. `fuse_addr_o` does not change while the clock is high, and the clock is only high while `fuse_en_o` is 1.
- R7: `fuse_dout_i` is sampled at the end of the low hold. `word_valid_o` rises LO_CYCLES cycles after the clock falls. Data and valid stay stable until `word_ready_i` accepts the word.
- R8: Power-down is the reverse of power-up. `fuse_en_o` falls in the cycle after the last word is accepted. `fuse_trim_o` falls STEP_CYCLES cycles later. `fuse_stby_no` falls STEP_CYCLES cycles after that, in the same cycle as the one-cycle `done_o` pulse.
- R9: While a request is running, `req_ready_o` is 0 and `req_valid_i` has no effect.
- R10: A valid request with length 0 performs the full power-up and power-down with no clock pulse and no word. `fuse_en_o` falls STEP_CYCLES cycles after it rises.
- R11: Words are read from consecutive indices start, start+1, … start+count-1, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_offset_i | input | 32 | Start byte offset (signed) |
| req_len_i | input | 32 | Byte length (signed) |
| word_valid_o | output | 1 | Read word available |
| word_ready_i | input | 1 | Consumer takes the word |
| word_data_o | output | 32 | Read word |
| done_o | output | 1 | One-cycle pulse at the end of an accepted request |
| err_o | output | 1 | One-cycle pulse on a rejected request |
| fuse_addr_o | output | $clog2(FUSE_COUNT) | Word index to the macro |
| fuse_clk_o | output | 1 | Macro clock |
| fuse_en_o | output | 1 | Macro enable |
| fuse_trim_o | output | 1 | Macro trim enable |
| fuse_stby_no | output | 1 | Deep standby control, active low (1 = awake) |
| fuse_dout_i | input | 32 | Macro data-out bus |

## Verification
A rejected request raises `err_o` in the first cycle after the edge that accepts it and clears it one cycle later. The bench samples on the two falling clock edges that follow that acceptance edge.

For accepted requests, a monitor stamps every pin edge with a cycle count taken at the falling clock edge. The checks then compare differences between stamps against the required spacings:
- STEP_CYCLES between pin steps;
- HI_CYCLES for the clock high phase;
- LO_CYCLES from the clock fall to the rise of valid;
- one cycle from address setup to the clock rise.

This means no check depends on an absolute cycle number. The bench also holds `word_ready_i` low for several cycles to confirm that valid and data stay stable.

// File: rtl/otp_read_pkg.sv
package otp_read_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_STBY,
    ST_UP_TRIM,
    ST_UP_EN,
    ST_ADDR,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_OUT,
    ST_DN_EN,
    ST_DN_TRIM
  } seq_state_e;
endpackage

// File: rtl/otp_req_check.sv
module otp_req_check #(
  parameter int FUSE_COUNT = 4096,
  parameter int AW = 12,
  parameter int CW = 13
) (
  input  logic [31:0]   offset_i,
  input  logic [31:0]   len_i,
  output logic          ok_o,
  output logic [AW-1:0] start_o,
  output logic [CW-1:0] count_o
);
  localparam logic [30:0] LIMIT = 31'(FUSE_COUNT);

  logic [29:0] start_w, count_w;
  logic [30:0] end_w;
  logic        aligned, nonneg, in_range;

  assign start_w  = offset_i[31:2];
  assign count_w  = len_i[31:2];
  assign end_w    = {1'b0, start_w} + {1'b0, count_w};
  assign aligned  = (offset_i[1:0] == 2'b00) && (len_i[1:0] == 2'b00);
  assign nonneg   = !offset_i[31] && !len_i[31];
  assign in_range = ({1'b0, start_w} < LIMIT) && (end_w <= LIMIT);
  assign ok_o     = aligned && nonneg && in_range;
  assign start_o  = start_w[AW-1:0];
  assign count_o  = count_w[CW-1:0];
endmodule

// File: rtl/otp_delay_timer.sv
module otp_delay_timer #(
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
  import otp_read_pkg::*;
#(
  parameter int FUSE_COUNT  = 4096,
  parameter int HI_CYCLES   = 2000,
  parameter int LO_CYCLES   = 500,
  parameter int STEP_CYCLES = 1,
  localparam int AW = $clog2(FUSE_COUNT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [31:0]   req_offset_i,
  input  logic [31:0]   req_len_i,
  output logic          word_valid_o,
  input  logic          word_ready_i,
  output logic [31:0]   word_data_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] fuse_addr_o,
  output logic          fuse_clk_o,
  output logic          fuse_en_o,
  output logic          fuse_trim_o,
  output logic          fuse_stby_no,
  input  logic [31:0]   fuse_dout_i
);
  localparam int CW   = $clog2(FUSE_COUNT + 1);
  localparam int MAXA = (HI_CYCLES > LO_CYCLES) ? HI_CYCLES : LO_CYCLES;
  localparam int MAXD = (MAXA > STEP_CYCLES) ? MAXA : STEP_CYCLES;
  localparam int TW   = $clog2(MAXD + 1);
  localparam logic [TW-1:0] HI_M1   = TW'(HI_CYCLES - 1);
  localparam logic [TW-1:0] LO_M1   = TW'(LO_CYCLES - 1);
  localparam logic [TW-1:0] STEP_M1 = TW'(STEP_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic          req_ok;
  logic [AW-1:0] req_start;
  logic [CW-1:0] req_count;
  logic [AW-1:0] idx_q, addr_q;
  logic [CW-1:0] rem_q;
  logic [31:0]   data_q;
  logic          valid_q, done_q, err_q;
  logic          clk_q, en_q, trim_q, stby_n_q;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          accept, hshake, sample;

  otp_req_check #(.FUSE_COUNT(FUSE_COUNT), .AW(AW), .CW(CW)) u_check (
    .offset_i (req_offset_i),
    .len_i    (req_len_i),
    .ok_o     (req_ok),
    .start_o  (req_start),
    .count_o  (req_count)
  );

  otp_delay_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign hshake      = (state_q == ST_OUT) && word_ready_i;
  assign sample      = (state_q == ST_CLK_LO) && tmr_zero;

  // Timed states last (load value + 1) cycles.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = STEP_M1;
    unique case (state_q)
      ST_IDLE: if (accept && req_ok) begin
        state_d = ST_UP_STBY; tmr_load = 1'b1;
      end
      ST_UP_STBY: if (tmr_zero) begin
        state_d = ST_UP_TRIM; tmr_load = 1'b1;
      end
      ST_UP_TRIM: if (tmr_zero) begin
        state_d = ST_UP_EN; tmr_load = 1'b1;
      end
      ST_UP_EN: if (tmr_zero) begin
        if (rem_q == '0) begin
          state_d = ST_DN_EN; tmr_load = 1'b1;
        end else begin
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        state_d = ST_CLK_HI; tmr_load = 1'b1; tmr_val = HI_M1;
      end
      ST_CLK_HI: if (tmr_zero) begin
        state_d = ST_CLK_LO; tmr_load = 1'b1; tmr_val = LO_M1;
      end
      ST_CLK_LO: if (tmr_zero) state_d = ST_OUT;
      ST_OUT: if (word_ready_i) begin
        if (rem_q == CW'(1)) begin
          state_d = ST_DN_EN; tmr_load = 1'b1;
        end else begin
          state_d = ST_ADDR;
        end
      end
      ST_DN_EN: if (tmr_zero) begin
        state_d = ST_DN_TRIM; tmr_load = 1'b1;
      end
      ST_DN_TRIM: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      clk_q    <= 1'b0;
      en_q     <= 1'b0;
      trim_q   <= 1'b0;
      stby_n_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // Pins are a registered decode of the next state: glitch-free, ordered.
      stby_n_q <= (state_d != ST_IDLE);
      trim_q   <= !(state_d inside {ST_IDLE, ST_UP_STBY, ST_DN_TRIM});
      en_q     <= state_d inside {ST_UP_EN, ST_ADDR, ST_CLK_HI, ST_CLK_LO, ST_OUT};
      clk_q    <= (state_d == ST_CLK_HI);
      done_q   <= (state_q == ST_DN_TRIM) && tmr_zero;
      err_q    <= accept && !req_ok;
      if (accept && req_ok) begin
        idx_q <= req_start;
        rem_q <= req_count;
      end
      if (state_d == ST_ADDR)
        addr_q <= (state_q == ST_OUT) ? idx_q + AW'(1) : idx_q;
      if (sample) begin
        data_q  <= fuse_dout_i;
        valid_q <= 1'b1;
      end else if (hshake) begin
        valid_q <= 1'b0;
      end
      if (hshake) begin
        idx_q <= idx_q + AW'(1);
        rem_q <= rem_q - CW'(1);
      end
    end
  end

  assign word_valid_o = valid_q;
  assign word_data_o  = data_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign fuse_addr_o  = addr_q;
  assign fuse_clk_o   = clk_q;
  assign fuse_en_o    = en_q;
  assign fuse_trim_o  = trim_q;
  assign fuse_stby_no = stby_n_q;

  // Checker-side run length of the macro clock high phase.
  logic [31:0] hi_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= '0;
    else if (fuse_clk_o) hi_run <= hi_run + 32'd1;
    else                 hi_run <= '0;
  end

  a_r1_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !fuse_en_o && !fuse_trim_o && !fuse_stby_no && !fuse_clk_o && !word_valid_o);
  a_r2_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_ready_o && !fuse_stby_no && !done_o);
  a_r5_trim_after_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fuse_trim_o) |-> fuse_stby_no && !fuse_en_o);
  a_r5_en_after_trim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fuse_en_o) |-> fuse_trim_o && fuse_stby_no);
  a_r6_clk_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_clk_o |-> fuse_en_o);
  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_clk_o && $past(fuse_clk_o) |-> $stable(fuse_addr_o));
  a_r6_hi_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fuse_clk_o) |-> hi_run == HI_CYCLES);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_data_o));
  a_r7_no_clk_while_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !fuse_clk_o && fuse_en_o);
  a_r8_trim_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fuse_trim_o) |-> !fuse_en_o && fuse_stby_no);
  a_r8_done_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(fuse_stby_no) && !err_o);
endmodule

// File: tb/otp_read_seq_bench.sv
`timescale 1ns/1ps
module otp_read_seq_bench;
  localparam int FC = 64;
  localparam int HI = 6;
  localparam int LO = 3;
  localparam int ST = 2;
  localparam int AW = $clog2(FC);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_offset = '0;
  logic [31:0]   req_len = '0;
  logic          word_valid;
  logic          word_ready = 1'b0;
  logic [31:0]   word_data;
  logic          done, err;
  logic [AW-1:0] f_addr;
  logic          f_clk, f_en, f_trim, f_stby_n;
  logic [31:0]   f_dout;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  otp_read_seq #(.FUSE_COUNT(FC), .HI_CYCLES(HI), .LO_CYCLES(LO), .STEP_CYCLES(ST)) u_otp_read_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_offset_i(req_offset), .req_len_i(req_len),
    .word_valid_o(word_valid), .word_ready_i(word_ready), .word_data_o(word_data),
    .done_o(done), .err_o(err),
    .fuse_addr_o(f_addr), .fuse_clk_o(f_clk), .fuse_en_o(f_en),
    .fuse_trim_o(f_trim), .fuse_stby_no(f_stby_n), .fuse_dout_i(f_dout)
  );

  function automatic logic [31:0] fuse_word(int a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0001_0101);
  endfunction

  // Macro model: latches the address while clocked, garbage while high.
  logic [AW-1:0] lat_addr = '0;
  always @(posedge clk) if (f_clk) lat_addr <= f_addr;
  assign f_dout = f_clk ? 32'hDEAD_BEEF : fuse_word(int'(lat_addr));

  // Edge monitor, stamps in cycles, sampled at falling edge.
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int t_stby_up, t_trim_up, t_en_up, t_stby_dn, t_trim_dn, t_en_dn, t_done, t_vfall;
  int rise_c, fall_c, n_rise, n_words, n_err, hi_bad, lo_bad, gap_bad, addr_bad;
  int addr_log [16];
  logic [AW-1:0] rise_addr;
  logic p_stby = 0, p_trim = 0, p_en = 0, p_clk = 0, p_valid = 0;

  task automatic clear_mon();
    t_stby_up = -1; t_trim_up = -1; t_en_up = -1;
    t_stby_dn = -1; t_trim_dn = -1; t_en_dn = -1; t_done = -1; t_vfall = -1;
    n_rise = 0; n_words = 0; n_err = 0;
    hi_bad = 0; lo_bad = 0; gap_bad = 0; addr_bad = 0;
  endtask

  always @(negedge clk) begin
    if (f_stby_n && !p_stby) t_stby_up = cyc;
    if (!f_stby_n && p_stby) t_stby_dn = cyc;
    if (f_trim && !p_trim)   t_trim_up = cyc;
    if (!f_trim && p_trim)   t_trim_dn = cyc;
    if (f_en && !p_en)       t_en_up = cyc;
    if (!f_en && p_en)       t_en_dn = cyc;
    if (f_clk && !p_clk) begin
      rise_c = cyc; rise_addr = f_addr;
      if (n_rise < 16) addr_log[n_rise] = int'(f_addr);
      if (n_rise == 0 && cyc - t_en_up != ST + 1) gap_bad++;
      if (n_rise > 0 && cyc - t_vfall != 1) gap_bad++;
      n_rise++;
    end
    if (f_clk && f_addr != rise_addr) addr_bad++;
    if (!f_clk && p_clk) begin
      if (cyc - rise_c != HI) hi_bad++;
      fall_c = cyc;
    end
    if (word_valid && !p_valid) begin
      if (cyc - fall_c != LO) lo_bad++;
      n_words++;
    end
    if (!word_valid && p_valid) t_vfall = cyc;
    if (done) t_done = cyc;
    if (err) n_err++;
    p_stby = f_stby_n; p_trim = f_trim; p_en = f_en; p_clk = f_clk; p_valid = word_valid;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
    chk({f_stby_n, f_trim, f_en, f_clk} == 4'b0, "R1", "pins", {f_stby_n, f_trim, f_en, f_clk}, 0);
    chk({word_valid, done, err} == 3'b0, "R1", "valid/done/err", {word_valid, done, err}, 0);
  endtask

  task automatic t_reject(logic [31:0] off, logic [31:0] len, string req);
    clear_mon();
    @(negedge clk);
    req_offset = off; req_len = len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1, req, "err pulse", err, 1);
    @(negedge clk);
    chk(err == 0, req, "err one cycle", err, 0);
    chk(req_ready == 1, req, "idle after reject", req_ready, 1);
    repeat (8) @(negedge clk);
    chk(t_stby_up == -1 && n_rise == 0 && n_words == 0, req, "no pin activity",
        t_stby_up, -1);
  endtask

  task automatic t_read(int start, int nw, int stall, bit poke);
    logic [31:0] held;
    int guard;
    clear_mon();
    @(negedge clk);
    req_offset = 32'(start * 4); req_len = 32'(nw * 4); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 0, "R9", "busy after accept", req_ready, 0);
    if (poke) begin
      req_offset = 32'h2; req_len = 32'h4; req_valid = 1'b1; // R9: ignored while busy
    end
    for (int i = 0; i < nw; i++) begin
      guard = 0;
      while (!word_valid && guard < 1000) begin @(negedge clk); guard++; end
      if (i == nw - 1) req_valid = 1'b0;
      chk(word_data == fuse_word(start + i), "R7", "word data", int'(word_data), int'(fuse_word(start + i)));
      held = word_data;
      for (int s = 0; s < stall; s++) @(negedge clk);
      if (stall > 0)
        chk(word_valid == 1 && word_data == held, "R7", "hold under stall", int'(word_data), int'(held));
      word_ready = 1'b1;
      @(negedge clk);
      word_ready = 1'b0;
    end
    guard = 0;
    while (t_done == -1 && guard < 2000) begin @(negedge clk); guard++; end
    req_valid = 1'b0;
    @(negedge clk);
    chk(n_words == nw, "R11", "word count", n_words, nw);
    for (int i = 0; i < nw && i < 16; i++)
      chk(addr_log[i] == start + i, "R11", "address order", addr_log[i], start + i);
    chk(t_trim_up - t_stby_up == ST, "R5", "stby->trim", t_trim_up - t_stby_up, ST);
    chk(t_en_up - t_trim_up == ST, "R5", "trim->en", t_en_up - t_trim_up, ST);
    if (nw > 0) begin
      chk(hi_bad == 0, "R6", "clock high length", hi_bad, 0);
      chk(gap_bad == 0, "R6", "address setup gap", gap_bad, 0);
      chk(addr_bad == 0, "R6", "address stable", addr_bad, 0);
      chk(lo_bad == 0, "R7", "low hold to valid", lo_bad, 0);
      chk(t_en_dn == t_vfall, "R8", "en falls after last accept", t_en_dn, t_vfall);
    end else begin
      chk(n_rise == 0, "R10", "no clock pulse", n_rise, 0);
      chk(t_en_dn - t_en_up == ST, "R10", "en width", t_en_dn - t_en_up, ST);
    end
    chk(t_trim_dn - t_en_dn == ST, "R8", "en->trim down", t_trim_dn - t_en_dn, ST);
    chk(t_stby_dn - t_trim_dn == ST, "R8", "trim->stby down", t_stby_dn - t_trim_dn, ST);
    chk(t_done == t_stby_dn, "R8", "done with stby", t_done, t_stby_dn);
    chk(n_err == 0, "R9", "no error from busy request", n_err, 0);
    chk(req_ready == 1, "R9", "idle at end", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reject(32'h2, 32'h4, "R2");
    t_reject(32'h0, 32'h6, "R2");
    t_reject(32'hFFFF_FFFC, 32'h4, "R3");
    t_reject(32'h0, 32'h8000_0000, "R3");
    t_reject(32'(FC * 4), 32'h0, "R4");
    t_reject(32'((FC - 4) * 4), 32'h14, "R4");
    t_read(0, 4, 0, 1'b0);
    t_read(FC - 2, 2, 3, 1'b1);   // R4: ends exactly at the limit
    t_read(8, 0, 0, 1'b0);        // R10
    t_read(30, 3, 1, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule